// File: doc/BRIEF.md
# Bus Transfer Error Capture with Correctable-Error Threshold

This block watches the error indications of a processor system bus and decides when a transfer must be ended with a transfer-error acknowledge. Error inputs are sampled each cycle, and the transfer code and transfer type of the transfer on the bus are sampled with them. The inputs are parity, single-bit ECC, double-bit ECC and an error reported by an external slave. A transfer-error acknowledge goes out as a one-cycle pulse. The details of the first failing transfer are kept in a status and control word that software reads and clears.

Single-bit (correctable) ECC errors are not reported while they are rare. Each one advances a saturating counter. Once the counter has reached its top value, every further correctable error is reported as a bus error. Software can preload the counter to reduce how many correctable errors are tolerated. A control bit masks all data errors (parity and both ECC kinds). Errors from an external slave are never masked.

Status/control word layout (default widths): bit 0 capture-valid (write 1 to clear the capture), bit 1 external-source flag, bits 4:2 captured transfer code, bits 9:5 captured transfer type, bit 12 data-error mask, bits 31:24 correctable-error counter. All other bits read 0. A write loads the mask bit and the counter from the written word.

Top module: `busErrCapture`

## Requirements
- R1: A single-bit ECC error with the mask bit clear and the counter below 255 increments the counter by one and raises no transfer-error acknowledge.
- R2: The counter stops at 255 and stays there under further single-bit errors.
- R3: A single-bit ECC error with the mask bit clear and the counter at 255 raises the transfer-error acknowledge.
- R4: A register write loads the counter from bits 31:24, and counting continues from that value. A write in the same cycle as a single-bit error takes the written value, with no increment.
- R5: With the mask bit (bit 12) set, parity, single-bit and double-bit ECC errors raise no acknowledge and leave the counter unchanged.
- R6: With the mask bit clear, a parity error or a double-bit ECC error raises the acknowledge with no counting.
- R7: An external-slave error raises the acknowledge whatever the mask bit holds, and the capture then sets the external flag (bit 1).
- R8: When an acknowledge is raised and no capture is held, the transfer code (bits 4:2) and transfer type (bits 9:5) are captured and capture-valid (bit 0) is set.
- R9: While capture-valid is set, later errors do not change the captured code, type or external flag.
- R10: Writing 1 to bit 0 clears capture-valid, the external flag and the captured fields.
- R11: The acknowledge is a one-cycle pulse that appears in the cycle after the error inputs are sampled.
- R12: After reset the whole word reads 0, and the reserved bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| parErr | input | 1 | Parity error on the current transfer |
| sbeErr | input | 1 | Single-bit ECC error on the current transfer |
| dbeErr | input | 1 | Double-bit ECC error on the current transfer |
| extErr | input | 1 | Error reported by an external slave |
| xferCode | input | TC_W | Transfer code of the current transfer |
| xferType | input | TT_W | Transfer type of the current transfer |
| regWrEn | input | 1 | Write strobe for the status/control word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Status/control word read value |
| teaPulse | output | 1 | Transfer-error acknowledge pulse |

## Verification
The bench builds the block with the default widths: an 8-bit counter, a 3-bit code and a 5-bit type. With these widths, all 256 code/type pairs can be captured, held against a second error and cleared in one sweep. Every combination of the four error inputs is applied with the mask bit set and clear and with the counter below and at saturation, so every path to the acknowledge is exercised. A preload near the top lets the run cross saturation in a few cycles, and a write in the same cycle as an increment shows which one wins.

// File: rtl/busErrPkg.sv
package busErrPkg;
  typedef struct packed {
    logic teaNow;    // an acknowledge is due this cycle
    logic extCause;  // external slave is among the causes
    logic incCnt;    // bump the correctable-error counter
    logic loadCnt;   // software loads counter and mask
    logic clrCap;    // software clears the capture
  } errStrobes_t;
endpackage

// File: rtl/busErrCtrl.sv
module busErrCtrl
  import busErrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        parErr,
  input  logic        sbeErr,
  input  logic        dbeErr,
  input  logic        extErr,
  input  logic        regWrEn,
  input  logic        clrBit,
  input  logic        dataDis,
  input  logic        cntAtMax,
  output errStrobes_t strb,
  output logic        teaPulse
);
  logic dataOn;
  logic sbeHit;

  always_comb begin
    dataOn        = !dataDis;
    sbeHit        = dataOn && sbeErr;
    strb.teaNow   = extErr || (dataOn && (parErr || dbeErr)) || (sbeHit && cntAtMax);
    strb.extCause = extErr;
    strb.incCnt   = sbeHit && !cntAtMax && !regWrEn;
    strb.loadCnt  = regWrEn;
    strb.clrCap   = regWrEn && clrBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) teaPulse <= 1'b0;
    else       teaPulse <= strb.teaNow;
  end

  p_ext_tea_r7: assert property (@(posedge clk) disable iff (!rstN)
    extErr |=> teaPulse);
  p_mask_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataDis && !extErr) |=> !teaPulse);
  p_data_tea_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!dataDis && (parErr || dbeErr)) |=> teaPulse);
endmodule

// File: rtl/busErrDatapath.sv
module busErrDatapath
  import busErrPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TC_W  = 3,
  parameter int TT_W  = 5,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  errStrobes_t      strb,
  input  logic [TC_W-1:0]  xferCode,
  input  logic [TT_W-1:0]  xferType,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             dataDis,
  output logic             cntAtMax
);
  localparam int CODE_LSB = 2;
  localparam int TYPE_LSB = CODE_LSB + TC_W;
  localparam int DIS_BIT  = TYPE_LSB + TT_W + 2;
  localparam int CNT_LSB  = REG_W - CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             capValid;
  logic             extFlag;
  logic [TC_W-1:0]  codeQ;
  logic [TT_W-1:0]  typeQ;
  logic [CNT_W-1:0] cntQ;
  logic             capLive;

  assign capLive  = capValid && !strb.clrCap;
  assign cntAtMax = (cntQ == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      dataDis <= 1'b0;
    end else begin
      if (strb.loadCnt) begin
        cntQ    <= wrData[CNT_LSB +: CNT_W];
        dataDis <= wrData[DIS_BIT];
      end else if (strb.incCnt) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValid <= 1'b0;
      extFlag  <= 1'b0;
      codeQ    <= '0;
      typeQ    <= '0;
    end else if (strb.teaNow && !capLive) begin
      capValid <= 1'b1;
      extFlag  <= strb.extCause;
      codeQ    <= xferCode;
      typeQ    <= xferType;
    end else if (strb.clrCap) begin
      capValid <= 1'b0;
      extFlag  <= 1'b0;
      codeQ    <= '0;
      typeQ    <= '0;
    end
  end

  always_comb begin
    rdData                       = '0;
    rdData[0]                    = capValid;
    rdData[1]                    = extFlag;
    rdData[CODE_LSB +: TC_W]     = codeQ;
    rdData[TYPE_LSB +: TT_W]     = typeQ;
    rdData[DIS_BIT]              = dataDis;
    rdData[CNT_LSB +: CNT_W]     = cntQ;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.incCnt |=> cntQ == CNT_W'($past(cntQ) + 1'b1));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntAtMax && !strb.loadCnt) |=> cntAtMax);
  p_load_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> cntQ == $past(wrData[CNT_LSB +: CNT_W]));
  p_capture_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && !strb.clrCap) |=> ($stable(codeQ) && $stable(typeQ) && $stable(extFlag) && capValid));
endmodule

// File: rtl/busErrCapture.sv
module busErrCapture
  import busErrPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TC_W  = 3,
  parameter int TT_W  = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            parErr,
  input  logic            sbeErr,
  input  logic            dbeErr,
  input  logic            extErr,
  input  logic [TC_W-1:0] xferCode,
  input  logic [TT_W-1:0] xferType,
  input  logic            regWrEn,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  output logic            teaPulse
);
  localparam int REG_W = 32;

  errStrobes_t strb;
  logic        dataDis;
  logic        cntAtMax;

  busErrCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .parErr   (parErr),
    .sbeErr   (sbeErr),
    .dbeErr   (dbeErr),
    .extErr   (extErr),
    .regWrEn  (regWrEn),
    .clrBit   (regWrData[0]),
    .dataDis  (dataDis),
    .cntAtMax (cntAtMax),
    .strb     (strb),
    .teaPulse (teaPulse)
  );

  busErrDatapath #(
    .CNT_W (CNT_W),
    .TC_W  (TC_W),
    .TT_W  (TT_W),
    .REG_W (REG_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .xferCode (xferCode),
    .xferType (xferType),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .dataDis  (dataDis),
    .cntAtMax (cntAtMax)
  );
endmodule

// File: tb/busErrCapture_tb.sv
module busErrCapture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        parErr = 0, sbeErr = 0, dbeErr = 0, extErr = 0;
  logic [2:0]  xferCode = '0;
  logic [4:0]  xferType = '0;
  logic        regWrEn = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        teaPulse;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busErrCapture dut_i (
    .clk(clk), .rstN(rstN), .parErr(parErr), .sbeErr(sbeErr), .dbeErr(dbeErr),
    .extErr(extErr), .xferCode(xferCode), .xferType(xferType), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .teaPulse(teaPulse)
  );

  function automatic logic [31:0] mkWord(bit cap, bit ext, logic [2:0] code,
                                         logic [4:0] typ, bit dis, logic [7:0] cnt);
    return {cnt, 11'd0, dis, 2'd0, typ, code, ext, cap};
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write at a falling edge; visible at the next falling edge
  task automatic writeReg(logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regWrData = d;
    @(negedge clk);
    regWrEn = 0; regWrData = '0;
  endtask

  // drive errors for one cycle; at return teaPulse shows the result
  task automatic hitErr(bit p, bit s, bit d, bit e, logic [2:0] c, logic [4:0] t);
    @(negedge clk);
    parErr = p; sbeErr = s; dbeErr = d; extErr = e; xferCode = c; xferType = t;
    @(negedge clk);
    parErr = 0; sbeErr = 0; dbeErr = 0; extErr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check32("R12 reset word", regRdData, 32'd0);
    check32("R12 reset tea", {31'd0, teaPulse}, 32'd0);

    // Exhaustive error combinations x mask x saturation (R3 R5 R6 R7 R1 R11)
    for (int dis = 0; dis < 2; dis++) begin
      for (int sat = 0; sat < 2; sat++) begin
        for (int e = 0; e < 16; e++) begin
          automatic logic [7:0] base = sat ? 8'd255 : 8'd10;
          automatic bit p = e[0], s = e[1], d = e[2], x = e[3];
          automatic bit expTea = x | (!dis & (p | d | (s & sat)));
          automatic logic [7:0] expCnt = (!dis && s && !sat) ? base + 8'd1 : base;
          writeReg({base, 11'd0, dis[0], 11'd0, 1'b1});
          hitErr(p, s, d, x, 3'(e), 5'(e + 3));
          check32("R3/R5/R6/R7 tea", {31'd0, teaPulse}, {31'd0, expTea});
          check32("R1/R5/R8 word", regRdData,
                  expTea ? mkWord(1, x, 3'(e), 5'(e + 3), dis[0], expCnt)
                         : mkWord(0, 0, 3'd0, 5'd0, dis[0], expCnt));
          @(negedge clk);
          check32("R11 single pulse", {31'd0, teaPulse}, 32'd0);
        end
      end
    end

    // Capture / hold / clear sweep over all code and type values (R8 R9 R10)
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 32; t++) begin
        writeReg(32'h1);
        hitErr(0, 0, 0, 1, 3'(c), 5'(t));
        check32("R8 capture", regRdData, mkWord(1, 1, 3'(c), 5'(t), 0, 8'd0));
        hitErr(1, 0, 0, 0, 3'(~c), 5'(~t));
        check32("R9 hold tea", {31'd0, teaPulse}, 32'd1);
        check32("R9 hold", regRdData, mkWord(1, 1, 3'(c), 5'(t), 0, 8'd0));
        writeReg(32'h1);
        check32("R10 clear", regRdData, 32'd0);
      end
    end

    // Threshold crossing (R1 R2 R3)
    writeReg({8'd250, 24'h1});
    for (int i = 0; i < 5; i++) begin
      hitErr(0, 1, 0, 0, 3'd0, 5'd0);
      check32("R1 no tea below max", {31'd0, teaPulse}, 32'd0);
      check32("R1 count", {24'd0, regRdData[31:24]}, 32'(251 + i));
    end
    hitErr(0, 1, 0, 0, 3'd5, 5'd17);
    check32("R3 tea at max", {31'd0, teaPulse}, 32'd1);
    check32("R2 saturate", regRdData, mkWord(1, 0, 3'd5, 5'd17, 0, 8'd255));
    hitErr(0, 1, 0, 0, 3'd0, 5'd0);
    check32("R2 still max", {24'd0, regRdData[31:24]}, 32'd255);

    // Write wins over a same-cycle increment (R4)
    writeReg({8'd40, 24'h1});
    @(negedge clk);
    regWrEn = 1; regWrData = {8'd100, 24'h0}; sbeErr = 1;
    @(negedge clk);
    regWrEn = 0; regWrData = '0; sbeErr = 0;
    check32("R4 write wins", {24'd0, regRdData[31:24]}, 32'd100);
    hitErr(0, 1, 0, 0, 3'd0, 5'd0);
    check32("R4 counts on", {24'd0, regRdData[31:24]}, 32'd101);

    // Reserved bits read zero (R12)
    writeReg(32'hFFFF_FFFF);
    check32("R12 reserved", regRdData, 32'hFF00_1000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule